// File: doc/BRIEF.md
# DRAM refresh scheduler

This block keeps every row of a 4096-row dynamic memory alive. A free-running interval counter raises a refresh tick often enough to cover all rows within the retention window. The window is 64 ms normally, or 128 ms when the long-period input is set. Each tick adds one entry to a small backlog. While the backlog is non-empty and no refresh is in progress, the block asks an external access sequencer for the memory. When the grant arrives, the block drives the row strobe, both column strobes and the address bus for exactly one refresh cycle, then pulses `done_o`.

Two refresh orderings are supported, chosen per cycle by `cbr_mode_i`:

- **Column-first ordering.** Both column strobes fall one setup interval before the row strobe. The memory supplies the row itself, and the address bus is held at zero.
- **Row-only ordering.** The column strobes stay high. The block presents its own row counter on the address bus while the row strobe pulses. The counter advances after each such cycle.

After reset the block runs a burst of 8 refreshes before it reports the memory as initialised. All cycle counts are derived from a clock-frequency parameter and a speed-grade parameter. At the default 100 MHz and fast grade, a refresh occupies 1 setup cycle, 5 row-low cycles and 4 precharge cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n_o` is 1, `cas_n_o` is 2'b11, and `req_o`, `done_o`, `init_done_o` and `overflow_o` are all 0.
- R2: With `long_period_i` = 0, successive refreshes are issued every floor(15625·CLK_MHZ/1000) cycles (1562 at 100 MHz). With `long_period_i` = 1 the spacing is floor(31250·CLK_MHZ/1000) cycles (3125).
- R3: Missed ticks accumulate up to 8 and are then issued back to back once granted. A tick arriving when 8 are already pending is dropped and sets `overflow_o`, which stays 1 until reset.
- R4: After reset, 8 refreshes are requested without waiting for a tick. `init_done_o` rises in the cycle after the eighth `done_o` pulse and stays 1.
- R5: In a column-first cycle, `cas_n_o` = 2'b00 for ceil(5·CLK_MHZ/1000) cycles with `ras_n_o` high. Then `ras_n_o` falls while `cas_n_o` stays 2'b00. Both strobes rise together, and `addr_o` is 0 throughout.
- R6: In a row-only cycle, `cas_n_o` stays 2'b11. `addr_o` carries the row counter for one setup cycle before `ras_n_o` falls and holds it until `ras_n_o` rises.
- R7: `ras_n_o` stays low for exactly ceil(tRAS·CLK_MHZ/1000) cycles, with tRAS = 50 ns (fast grade) or 60 ns. It then stays high for max(RP, RC−RAS) precharge cycles before `done_o`. Here RP and RC are the cycle counts of the 30/40 ns precharge and the 84/104 ns cycle time.
- R8: The row counter starts at 0 after reset and increments by one after each row-only cycle, not after a column-first cycle. It wraps from 2^ROW_BITS−1 to 0.
- R9: `req_o` is 1 only while idle with a pending refresh. The strobe sequence starts in the cycle after `req_o` and `gnt_i` are both 1 at a clock edge. No strobe moves without a grant, and `done_o` is a single-cycle pulse in the cycle after the last precharge cycle.
- R10: `cbr_mode_i` is sampled when a refresh is granted. `long_period_i` is sampled when the interval counter reloads, so a change first affects the interval that starts at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cbr_mode_i | input | 1 | 1 = column-first refresh, 0 = row-only refresh |
| long_period_i | input | 1 | 1 = 128 ms retention window, 0 = 64 ms |
| gnt_i | input | 1 | Grant from the access sequencer |
| req_o | output | 1 | Refresh request to the access sequencer |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 2 | Upper and lower column strobes, active low |
| addr_o | output | ROW_BITS | Row address in row-only cycles, else 0 |
| done_o | output | 1 | One-cycle pulse at the end of each refresh |
| init_done_o | output | 1 | Boot refresh burst complete |
| overflow_o | output | 1 | Sticky backlog overflow flag |

## Verification
The checker assumes the sequencer drives `gnt_i` cleanly and that `cbr_mode_i` changes only between refreshes. The bench keeps to this by toggling the mode and period selects only while `req_o` is low, right after a `done_o` pulse. Grants are either held high or withheld for whole multiples of the refresh interval, so the number of ticks missed is known exactly. The row counter is shrunk to 4 bits so that its wrap is reached within a short run.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        RF_IDLE,
        RF_SETUP,
        RF_RASLO,
        RF_PRECH
    } rf_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int SHORT_CYC = 1562,
    parameter int LONG_CYC  = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_i,
    output logic tick_o
);
    localparam int CW = $clog2(LONG_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == '0) begin
            st_d.cnt  = long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CW'(SHORT_CYC - 1);
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int MAX_PEND = 8,
    parameter int BOOT_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic done_i,
    output logic pending_o,
    output logic init_done_o,
    output logic overflow_o
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam int BW = $clog2(BOOT_CNT + 1);

    typedef struct packed {
        logic          armed;
        logic [PW-1:0] pend;
        logic [BW-1:0] boot;
        logic          ovf;
    } blg_t;

    blg_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        if (tick_i && !start_i) begin
            if (st_q.pend == PW'(MAX_PEND)) st_d.ovf  = 1'b1;
            else                            st_d.pend = st_q.pend + PW'(1);
        end else if (start_i && !tick_i) begin
            st_d.pend = st_q.pend - PW'(1);
        end
        if (done_i && st_q.boot != BW'(BOOT_CNT)) st_d.boot = st_q.boot + BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
            st_q.pend  <= PW'(BOOT_CNT);
            st_q.boot  <= '0;
            st_q.ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o   = st_q.armed && (st_q.pend != '0);
    assign init_done_o = (st_q.boot == BW'(BOOT_CNT));
    assign overflow_o  = st_q.ovf;
endmodule

// File: rtl/refresh_strobe_fsm.sv
module refresh_strobe_fsm
    import refresh_pkg::*;
#(
    parameter int ROW_BITS  = 12,
    parameter int SETUP_CYC = 1,
    parameter int RAS_CYC   = 5,
    parameter int PRE_CYC   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pending_i,
    input  logic                gnt_i,
    input  logic                cbr_i,
    output logic                req_o,
    output logic                start_o,
    output logic                done_o,
    output logic                ras_n_o,
    output logic [1:0]          cas_n_o,
    output logic [ROW_BITS-1:0] addr_o
);
    localparam int CW = $clog2(SETUP_CYC + RAS_CYC + PRE_CYC + 1);

    typedef struct packed {
        rf_state_e           state;
        logic [CW-1:0]       cnt;
        logic                cbr;
        logic [ROW_BITS-1:0] row;
        logic                done;
    } fsm_t;

    fsm_t st_d, st_q;

    assign req_o   = (st_q.state == RF_IDLE) && pending_i;
    assign start_o = req_o && gnt_i;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            RF_IDLE: if (start_o) begin
                st_d.state = RF_SETUP;
                st_d.cnt   = CW'(SETUP_CYC - 1);
                st_d.cbr   = cbr_i;
            end
            RF_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.state = RF_RASLO;
                    st_d.cnt   = CW'(RAS_CYC - 1);
                end else st_d.cnt = st_q.cnt - CW'(1);
            end
            RF_RASLO: begin
                if (st_q.cnt == '0) begin
                    st_d.state = RF_PRECH;
                    st_d.cnt   = CW'(PRE_CYC - 1);
                end else st_d.cnt = st_q.cnt - CW'(1);
            end
            RF_PRECH: begin
                if (st_q.cnt == '0) begin
                    st_d.state = RF_IDLE;
                    st_d.done  = 1'b1;
                    if (!st_q.cbr) st_d.row = st_q.row + ROW_BITS'(1);
                end else st_d.cnt = st_q.cnt - CW'(1);
            end
            default: st_d.state = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= RF_IDLE;
            st_q.cnt   <= '0;
            st_q.cbr   <= 1'b1;
            st_q.row   <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    logic active;
    assign active  = (st_q.state == RF_SETUP) || (st_q.state == RF_RASLO);
    assign ras_n_o = (st_q.state != RF_RASLO);
    assign cas_n_o = (active && st_q.cbr) ? 2'b00 : 2'b11;
    assign addr_o  = (active && !st_q.cbr) ? st_q.row : '0;
    assign done_o  = st_q.done;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refresh_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int ROW_BITS  = 12,
    parameter bit SLOW_GRADE = 1'b0,
    parameter int MAX_PEND  = 8,
    parameter int BOOT_CNT  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cbr_mode_i,
    input  logic                long_period_i,
    input  logic                gnt_i,
    output logic                req_o,
    output logic                ras_n_o,
    output logic [1:0]          cas_n_o,
    output logic [ROW_BITS-1:0] addr_o,
    output logic                done_o,
    output logic                init_done_o,
    output logic                overflow_o
);
    localparam int SHORT_CYC = (15625 * CLK_MHZ) / 1000;
    localparam int LONG_CYC  = (31250 * CLK_MHZ) / 1000;
    localparam int SETUP_CYC = ns_to_cyc(5, CLK_MHZ);
    localparam int RAS_CYC   = ns_to_cyc(SLOW_GRADE ? 60 : 50, CLK_MHZ);
    localparam int RP_CYC    = ns_to_cyc(SLOW_GRADE ? 40 : 30, CLK_MHZ);
    localparam int RC_CYC    = ns_to_cyc(SLOW_GRADE ? 104 : 84, CLK_MHZ);
    localparam int PRE_CYC   = (RC_CYC - RAS_CYC > RP_CYC) ? RC_CYC - RAS_CYC : RP_CYC;

    logic tick, pending, start;

    refresh_timer #(
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .long_i(long_period_i),
        .tick_o(tick)
    );

    refresh_backlog #(
        .MAX_PEND(MAX_PEND),
        .BOOT_CNT(BOOT_CNT)
    ) u_backlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (start),
        .done_i     (done_o),
        .pending_o  (pending),
        .init_done_o(init_done_o),
        .overflow_o (overflow_o)
    );

    refresh_strobe_fsm #(
        .ROW_BITS (ROW_BITS),
        .SETUP_CYC(SETUP_CYC),
        .RAS_CYC  (RAS_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending_i(pending),
        .gnt_i    (gnt_i),
        .cbr_i    (cbr_mode_i),
        .req_o    (req_o),
        .start_o  (start),
        .done_o   (done_o),
        .ras_n_o  (ras_n_o),
        .cas_n_o  (cas_n_o),
        .addr_o   (addr_o)
    );
endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
    parameter int ROW_BITS = 12,
    parameter int RAS_CYC  = 5,
    parameter int RP_CYC   = 3,
    parameter int RC_CYC   = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_o,
    input logic                ras_n_o,
    input logic [1:0]          cas_n_o,
    input logic [ROW_BITS-1:0] addr_o,
    input logic                done_o,
    input logic                init_done_o,
    input logic                overflow_o
);
    logic [15:0] low_cnt, high_cnt, last_low;
    logic        seen_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            high_cnt  <= '0;
            last_low  <= '0;
            seen_rise <= 1'b0;
        end else begin
            if (!ras_n_o) begin
                low_cnt  <= low_cnt + 16'd1;
                high_cnt <= '0;
            end else begin
                low_cnt <= '0;
                if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 16'd1;
                if (low_cnt != '0) begin
                    last_low  <= low_cnt;
                    seen_rise <= 1'b1;
                end
            end
        end
    end

    p_ras_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (low_cnt == 16'(RAS_CYC)));

    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && seen_rise) |-> (high_cnt >= 16'(RP_CYC)));

    p_cycle_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && seen_rise) |-> (last_low + high_cnt >= 16'(RC_CYC)));

    p_cbr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && cas_n_o == 2'b00) |-> ($past(cas_n_o) == 2'b00));

    p_cas_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n_o == 2'b00) || (cas_n_o == 2'b11));

    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && !$fell(ras_n_o)) |-> $stable(addr_o));

    p_req_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || cas_n_o != 2'b11) |-> !req_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_no_overflow_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    p_init_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);
endmodule

bind dram_refresh_sched refresh_sched_checker #(
    .ROW_BITS(ROW_BITS),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .RC_CYC  (RC_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_o      (req_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .addr_o     (addr_o),
    .done_o     (done_o),
    .init_done_o(init_done_o),
    .overflow_o (overflow_o)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 100;
    localparam int ROWB  = 4;
    localparam int SHORT = (15625 * MHZ) / 1000;
    localparam int LONG  = (31250 * MHZ) / 1000;
    localparam int SET_C = (5 * MHZ + 999) / 1000;
    localparam int RAS_C = (50 * MHZ + 999) / 1000;
    localparam int RP_C  = (30 * MHZ + 999) / 1000;
    localparam int RC_C  = (84 * MHZ + 999) / 1000;
    localparam int PRE_C = (RC_C - RAS_C > RP_C) ? RC_C - RAS_C : RP_C;

    logic clk = 1'b0;
    logic rst_n, cbr_mode, long_per, gnt;
    logic req, ras_n, done, init_done, ovf;
    logic [1:0] cas_n;
    logic [ROWB-1:0] addr;

    int total = 0;
    int bad = 0;
    longint cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sched #(.CLK_MHZ(MHZ), .ROW_BITS(ROWB)) dut (
        .clk(clk), .rst_n(rst_n), .cbr_mode_i(cbr_mode), .long_period_i(long_per),
        .gnt_i(gnt), .req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr),
        .done_o(done), .init_done_o(init_done), .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One granted refresh; returns the cycle of its done pulse.
    task automatic run_one(input bit cbr, input int row, output longint t_done);
        int w = 0;
        int lo = 0;
        int hi = 0;
        string tg;
        tg = cbr ? "R5" : "R6";
        while (!req && w < 10000) begin
            @(negedge clk);
            w++;
        end
        chk(req == 1'b1, "R9 request", req, 1);
        for (int i = 0; i < SET_C; i++) begin
            @(negedge clk);
            chk(ras_n == 1'b1, "R9 setup ras", ras_n, 1);
            chk(cas_n == (cbr ? 2'b00 : 2'b11), tg, cas_n, cbr ? 0 : 3);
            chk(addr == (cbr ? ROWB'(0) : ROWB'(row)), tg, addr, cbr ? 0 : row);
        end
        @(negedge clk);
        while (!ras_n && lo < 100) begin
            if (cas_n != (cbr ? 2'b00 : 2'b11)) chk(0, tg, cas_n, cbr ? 0 : 3);
            if (addr != (cbr ? ROWB'(0) : ROWB'(row))) chk(0, tg, addr, cbr ? 0 : row);
            lo++;
            @(negedge clk);
        end
        chk(lo == RAS_C, "R7 ras low", lo, RAS_C);
        while (!done && hi < 100) begin
            if (cas_n != 2'b11 || !ras_n) chk(0, "R7 precharge strobes", cas_n, 3);
            hi++;
            @(negedge clk);
        end
        chk(hi == PRE_C, "R7 precharge", hi, PRE_C);
        chk(done == 1'b1, "R9 done", done, 1);
        t_done = cyc;
    endtask

    initial begin
        longint t0, t1;
        int row_exp, n;
        rst_n = 1'b0; cbr_mode = 1'b1; long_per = 1'b0; gnt = 1'b0;
        repeat (3) @(negedge clk);
        chk(ras_n == 1'b1 && cas_n == 2'b11, "R1 strobes", {ras_n, cas_n}, 7);
        chk(!req && !done, "R1 req/done", {req, done}, 0);
        chk(!init_done && !ovf, "R1 flags", {init_done, ovf}, 0);
        rst_n = 1'b1;
        gnt = 1'b1;

        // R4 boot burst
        for (int k = 0; k < 8; k++) begin
            run_one(1'b1, 0, t0);
            chk(init_done == 1'b0, "R4 early", init_done, 0);
        end
        @(negedge clk);
        chk(init_done == 1'b1, "R4 init", init_done, 1);

        // R2 short spacing
        run_one(1'b1, 0, t0);
        for (int k = 0; k < 3; k++) begin
            run_one(1'b1, 0, t1);
            chk(t1 - t0 == SHORT, "R2 short", t1 - t0, SHORT);
            t0 = t1;
        end
        // R10 long period takes effect from the next reload
        long_per = 1'b1;
        run_one(1'b1, 0, t0);
        for (int k = 0; k < 2; k++) begin
            run_one(1'b1, 0, t1);
            chk(t1 - t0 == LONG, "R2 R10 long", t1 - t0, LONG);
            t0 = t1;
        end
        long_per = 1'b0;
        run_one(1'b1, 0, t0);
        chk(t0 - t1 == LONG, "R10 old period kept", t0 - t1, LONG);
        run_one(1'b1, 0, t1);
        chk(t1 - t0 == SHORT, "R2 back to short", t1 - t0, SHORT);

        // R8 row counter with wrap
        cbr_mode = 1'b0;
        row_exp = 0;
        for (int k = 0; k < 20; k++) begin
            run_one(1'b0, row_exp, t0);
            row_exp = (row_exp + 1) % (1 << ROWB);
        end
        cbr_mode = 1'b1;
        run_one(1'b1, 0, t0);
        cbr_mode = 1'b0;
        run_one(1'b0, row_exp, t0);   // R8: column-first cycle left the row alone
        row_exp = (row_exp + 1) % (1 << ROWB);
        cbr_mode = 1'b1;

        // R3 backlog of five
        gnt = 1'b0;
        repeat (5 * SHORT) @(negedge clk);
        chk(req == 1'b1, "R9 waiting req", req, 1);
        chk(ras_n == 1'b1 && cas_n == 2'b11, "R9 no grant no strobe", {ras_n, cas_n}, 7);
        gnt = 1'b1;
        n = 0;
        do begin
            run_one(1'b1, 0, t0);
            n++;
        end while (req && n < 20);
        chk(n == 5, "R3 backlog", n, 5);
        chk(ovf == 1'b0, "R3 no overflow", ovf, 0);

        // R3 overflow
        gnt = 1'b0;
        repeat (10 * SHORT) @(negedge clk);
        chk(ovf == 1'b1, "R3 overflow set", ovf, 1);
        gnt = 1'b1;
        n = 0;
        do begin
            run_one(1'b1, 0, t0);
            n++;
        end while (req && n < 20);
        chk(n == 8, "R3 capped burst", n, 8);
        chk(ovf == 1'b1, "R3 overflow sticky", ovf, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule